// File: doc/BRIEF.md
# SRAM Bus Gating Controller with Register Window and Power-Fail Hold-Off

This block sits between a byte-wide host bus and an external static RAM. The host bus has 17 address lines and active-low chip enable, output enable and write enable. The lowest 64 addresses belong to an on-chip register window: 14 clock registers followed by 50 general bytes. Every other address reaches the SRAM. The block passes the host chip enable to the SRAM, and passes output enable only for accesses outside the window. Because SRAM output enable is held off inside the window, the on-chip registers cover the bottom of the SRAM without any visible gap.

The block also decodes host write cycles aimed at the window and hands each one, with its index and data, to the register storage as a single-cycle strobe. A digital power-good input stands in for the analog supply comparator. While power is bad, the block blocks both the SRAM and the window. After power returns, a hold-off of 4915 ticks of a 32.768 kHz enable (150 ms) keeps that protection in place, and a power-fail flag stays asserted for the same period. All sequential logic runs on one system clock. The host bus strobes are assumed to be synchronous to that clock.

Top module: `sram_bus_gate`

## Requirements
- R1: `reg_sel` is 1 exactly when `ce_n` is 0, the address is below 0x40, `pfo_n` is 1 and `power_good` is 1. `reg_idx` carries the low six address bits.
- R2: `oer_n` equals `oe_n` when `ce_n` is 0, the address is 0x40 or above, `pfo_n` is 1 and `power_good` is 1. In every other case `oer_n` is 1, including every access inside the window.
- R3: `ceo_n` equals `ce_n` while `pfo_n` is 1 and `power_good` is 1. Otherwise `ceo_n` is 1, including for external accesses during the hold-off.
- R4: `drive_en` is 1 when `reg_sel` is 1, `oe_n` is 0 and `we_n` is 1.
- R5: `drive_en` is 0 whenever `we_n` is 0.
- R6: A window write lasts while `reg_sel` is 1 and `we_n` is 0. It ends when either `ce_n` or `we_n` rises. In the cycle after it ends, `wr_stb` is 1 for exactly one cycle. At that point `wr_addr` and `wr_data` hold the index and data sampled on the last clock edge of the write. Writes to addresses 0x40 and above give no strobe.
- R7: A write attempted while `pfo_n` is 0 gives no `wr_stb`.
- R8: After `power_good` rises, it passes a two-stage synchronizer. `pfo_n` then stays 0 through 4914 `tick_32k` pulses and goes to 1 on the clock edge that samples the 4915th pulse.
- R9: If `power_good` falls during the hold-off, `pfo_n` stays 0 and the tick count restarts from zero when power returns.
- R10: During and just after reset, `pfo_n` is 0, `ceo_n` and `oer_n` are 1 and `wr_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz |
| power_good | input | 1 | Supply in tolerance (1) |
| addr | input | 17 | Host address |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| din | input | 8 | Host write data |
| ceo_n | output | 1 | SRAM chip enable, active low |
| oer_n | output | 1 | SRAM output enable, active low |
| pfo_n | output | 1 | Power-fail flag, active low |
| reg_sel | output | 1 | On-chip window selected |
| reg_idx | output | 6 | Selected window index |
| drive_en | output | 1 | Drive window read data onto the host bus |
| wr_stb | output | 1 | One-cycle window write strobe |
| wr_addr | output | 6 | Index of the completed window write |
| wr_data | output | 8 | Data of the completed window write |

## Verification
On every cycle the assertions check four things: that no address inside the window ever enables SRAM output, that a low power-good input blocks both SRAM strobes, that the bus drive is released while write enable is low, and that the write strobe is a single-cycle pulse issued only while the power-fail flag was inactive. They also check that the flag can only clear on a tick. Other behaviours need bench scenarios: the exact 4915-tick length of the hold-off, the restart of the count after a brown-out during recovery, the data captured at the end of a write, and the suppression of SRAM chip enable for external accesses made during recovery.

// File: rtl/sram_gate_pkg.sv
package sram_gate_pkg;
  localparam int ADDR_W    = 17;
  localparam int DATA_W    = 8;
  localparam int WIN_WORDS = 64;
  localparam int IDX_W     = $clog2(WIN_WORDS);

  typedef enum logic [1:0] {
    PW_FAIL = 2'd0,
    PW_HOLD = 2'd1,
    PW_OK   = 2'd2
  } pw_state_e;
endpackage

// File: rtl/win_decode.sv
module win_decode #(
  parameter int AW    = 17,
  parameter int WORDS = 64,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic [AW-1:0] addr,
  output logic          in_win,
  output logic [IW-1:0] idx
);
  localparam logic [AW-1:0] WIN_LIMIT = AW'(WORDS);

  always_comb begin
    in_win = (addr < WIN_LIMIT);
    idx    = addr[IW-1:0];
  end
endmodule

// File: rtl/pwr_holdoff.sv
module pwr_holdoff
  import sram_gate_pkg::*;
#(
  parameter int HOLD_TICKS  = 4915,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pg_async,
  output logic pw_ok
);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   pg_s;
  pw_state_e              state_q, state_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   cnt_en;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pg_async};
    pg_s   = sync_q[SYNC_STAGES-1];
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      PW_FAIL: begin
        cnt_en = 1'b1;
        cnt_d  = '0;
        if (pg_s) state_d = PW_HOLD;
      end
      PW_HOLD: begin
        if (!pg_s) begin
          state_d = PW_FAIL;
          cnt_en  = 1'b1;
          cnt_d   = '0;
        end else if (tick) begin
          cnt_en = 1'b1;
          if (cnt_q == LAST) begin
            state_d = PW_OK;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PW_OK: begin
        if (!pg_s) state_d = PW_FAIL;
      end
      default: state_d = PW_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      state_q <= PW_FAIL;
    end else begin
      sync_q  <= sync_d;
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb pw_ok = (state_q == PW_OK);
endmodule

// File: rtl/wr_capture.sv
module wr_capture #(
  parameter int IW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_act,
  input  logic          blocked,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] din,
  output logic          wr_stb,
  output logic [IW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          act_q;
  logic          stb_q, stb_d;
  logic [IW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          cap_en;

  always_comb begin
    cap_en = wr_act;
    stb_d  = act_q & ~wr_act & ~blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      act_q <= wr_act;
      stb_q <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= idx;
      data_q <= din;
    end
  end

  always_comb begin
    wr_stb  = stb_q;
    wr_addr = addr_q;
    wr_data = data_q;
  end
endmodule

// File: rtl/sram_bus_gate.sv
module sram_bus_gate
  import sram_gate_pkg::*;
#(
  parameter int HOLD_TICKS = 4915
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              power_good,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] din,
  output logic              ceo_n,
  output logic              oer_n,
  output logic              pfo_n,
  output logic              reg_sel,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              drive_en,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic             pw_ok;
  logic             allow;
  logic             wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  always_comb rst_n_s = rst_sync_q[1];

  win_decode #(.AW(ADDR_W), .WORDS(WIN_WORDS)) u_dec (
    .addr   (addr),
    .in_win (in_win),
    .idx    (idx)
  );

  pwr_holdoff #(.HOLD_TICKS(HOLD_TICKS), .SYNC_STAGES(2)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick     (tick_32k),
    .pg_async (power_good),
    .pw_ok    (pw_ok)
  );

  always_comb begin
    allow    = pw_ok & power_good;
    pfo_n    = pw_ok;
    ceo_n    = ce_n | ~allow;
    oer_n    = ~(allow & ~ce_n & ~in_win & ~oe_n);
    reg_sel  = allow & ~ce_n & in_win;
    reg_idx  = idx;
    drive_en = reg_sel & ~oe_n & we_n;
    wr_act   = reg_sel & ~we_n;
  end

  wr_capture #(.IW(IDX_W), .DW(DATA_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_act  (wr_act),
    .blocked (~allow),
    .idx     (idx),
    .din     (din),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );
endmodule

// File: rtl/sram_bus_gate_chk.sv
module sram_bus_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_32k,
  input logic        power_good,
  input logic [16:0] addr,
  input logic        we_n,
  input logic        ceo_n,
  input logic        oer_n,
  input logic        pfo_n,
  input logic        reg_sel,
  input logic        drive_en,
  input logic        wr_stb
);
  AST_WIN_NO_OER: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < 17'h40) |-> oer_n); // R2
  AST_SEL_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (addr < 17'h40)); // R1
  AST_PG_LOW_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !power_good |-> (ceo_n && oer_n)); // R3
  AST_PFO_BLOCKS_CEO: assert property (@(posedge clk) disable iff (!rst_n)
    !pfo_n |-> ceo_n); // R3
  AST_DRIVE_OFF_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !drive_en); // R5
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R6
  AST_STB_NOT_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(pfo_n)); // R7
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfo_n) |-> $past(tick_32k)); // R8
endmodule

bind sram_bus_gate sram_bus_gate_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_32k   (tick_32k),
  .power_good (power_good),
  .addr       (addr),
  .we_n       (we_n),
  .ceo_n      (ceo_n),
  .oer_n      (oer_n),
  .pfo_n      (pfo_n),
  .reg_sel    (reg_sel),
  .drive_en   (drive_en),
  .wr_stb     (wr_stb)
);

// File: tb/sram_bus_gate_tb.sv
module sram_bus_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_32k;
  logic        power_good;
  logic [16:0] addr;
  logic        ce_n, oe_n, we_n;
  logic [7:0]  din;
  logic        ceo_n, oer_n, pfo_n, reg_sel, drive_en, wr_stb;
  logic [5:0]  reg_idx, wr_addr;
  logic [7:0]  wr_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sram_bus_gate dut_i (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .power_good(power_good),
    .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .din(din),
    .ceo_n(ceo_n), .oer_n(oer_n), .pfo_n(pfo_n), .reg_sel(reg_sel),
    .reg_idx(reg_idx), .drive_en(drive_en), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // fields: addr[16:0], ce_n, oe_n, we_n, exp ceo_n, exp oer_n, exp reg_sel, exp drive_en
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    {17'h00005, 3'b001, 4'b0111},
    {17'h0003F, 3'b001, 4'b0111},
    {17'h00040, 3'b001, 4'b0000},
    {17'h1FFFF, 3'b001, 4'b0000},
    {17'h00010, 3'b101, 4'b1100},
    {17'h00100, 3'b101, 4'b1100},
    {17'h00020, 3'b011, 4'b0110},
    {17'h00020, 3'b000, 4'b0110},
    {17'h00400, 3'b010, 4'b0100},
    {17'h0000D, 3'b001, 4'b0111}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_32k = 1'b1;
      @(negedge clk) tick_32k = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    rst_n = 1'b0; tick_32k = 1'b0; power_good = 1'b0;
    idle();
    ce_n = 1'b0; oe_n = 1'b0; addr = 17'h00200;
    repeat (4) @(negedge clk);
    check(pfo_n == 1'b0, "R10 pfo_n in reset", pfo_n, 0);
    check(ceo_n == 1'b1, "R10 ceo_n in reset", ceo_n, 1);
    check(oer_n == 1'b1, "R10 oer_n in reset", oer_n, 1);
    check(wr_stb == 1'b0, "R10 wr_stb in reset", wr_stb, 0);
    rst_n = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    check(pfo_n == 1'b0, "R10 pfo_n after reset", pfo_n, 0);

    // power-up hold-off R8, with external access during it R3
    power_good = 1'b1;
    repeat (4) @(negedge clk);
    ticks(4914);
    @(negedge clk);
    check(pfo_n == 1'b0, "R8 still held after 4914 ticks", pfo_n, 0);
    addr = 17'h00100; ce_n = 1'b0; oe_n = 1'b0;
    #1;
    check(ceo_n == 1'b1, "R3 ceo_n blocked in hold-off", ceo_n, 1);
    check(oer_n == 1'b1, "R2 oer_n blocked in hold-off", oer_n, 1);
    idle();
    ticks(1);
    @(negedge clk);
    check(pfo_n == 1'b1, "R8 released on 4915th tick", pfo_n, 1);

    // table walk R1 R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      addr = VEC[v][23:7]; ce_n = VEC[v][6]; oe_n = VEC[v][5]; we_n = VEC[v][4];
      #1;
      check(ceo_n == VEC[v][3], "R3 ceo_n vector", ceo_n, VEC[v][3]);
      check(oer_n == VEC[v][2], "R2 oer_n vector", oer_n, VEC[v][2]);
      check(reg_sel == VEC[v][1], "R1 reg_sel vector", reg_sel, VEC[v][1]);
      check(drive_en == VEC[v][0], "R4 R5 drive_en vector", drive_en, VEC[v][0]);
      if (VEC[v][1])
        check(reg_idx == VEC[v][12:7], "R1 reg_idx vector", reg_idx, VEC[v][12:7]);
    end
    @(negedge clk) idle();
    repeat (3) @(negedge clk);

    // write ended by WE R6
    addr = 17'h00005; din = 8'hA5; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    din = 8'h3C;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    check(wr_stb == 1'b1, "R6 strobe after WE rise", wr_stb, 1);
    check(wr_addr == 6'h05, "R6 write index", wr_addr, 6'h05);
    check(wr_data == 8'h3C, "R6 write data last sampled", wr_data, 8'h3C);
    @(negedge clk);
    check(wr_stb == 1'b0, "R6 strobe one cycle", wr_stb, 0);
    idle();

    // write ended by CE R6
    @(negedge clk);
    addr = 17'h0002A; din = 8'h77; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    check(wr_stb == 1'b1 && wr_addr == 6'h2A && wr_data == 8'h77,
          "R6 strobe after CE rise", {wr_stb, wr_addr, wr_data}, {1'b1, 6'h2A, 8'h77});
    idle();

    // external write gives no strobe R6
    @(negedge clk);
    addr = 17'h00080; din = 8'h11; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    idle();
    seen = 1'b0;
    repeat (3) begin @(negedge clk); seen |= wr_stb; end
    check(seen == 1'b0, "R6 no strobe for external write", seen, 0);

    // power loss: immediate block R3, then write ignored R7
    power_good = 1'b0; ce_n = 1'b0; addr = 17'h00300;
    #1;
    check(ceo_n == 1'b1, "R3 ceo_n on power loss", ceo_n, 1);
    idle();
    repeat (4) @(negedge clk);
    check(pfo_n == 1'b0, "R7 pfo_n active after loss", pfo_n, 0);
    power_good = 1'b1;
    @(negedge clk);
    addr = 17'h00010; din = 8'h99; ce_n = 1'b0; we_n = 1'b0;
    #1;
    check(reg_sel == 1'b0, "R7 window blocked", reg_sel, 0);
    repeat (2) @(negedge clk);
    idle();
    seen = 1'b0;
    repeat (3) begin @(negedge clk); seen |= wr_stb; end
    check(seen == 1'b0, "R7 no strobe while protected", seen, 0);

    // brown-out during hold-off restarts count R9
    repeat (4) @(negedge clk);
    ticks(3000);
    power_good = 1'b0;
    repeat (4) @(negedge clk);
    check(pfo_n == 1'b0, "R9 pfo_n after brown-out", pfo_n, 0);
    power_good = 1'b1;
    repeat (4) @(negedge clk);
    ticks(4914);
    @(negedge clk);
    check(pfo_n == 1'b0, "R9 count restarted", pfo_n, 0);
    ticks(1);
    @(negedge clk);
    check(pfo_n == 1'b1, "R9 released after full count", pfo_n, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule